// File: doc/BRIEF.md
# Half-Step Constant-Torque Stepper Sequencer

This block drives two chopper bridges that power the two windings of a bipolar stepper motor. It walks the motor through an eight-position half-step cycle. For each winding it produces a direction bit and a two-bit current-select code. A one-cycle step strobe advances the position. A direction input chooses whether the table is walked forward or backward.

The current level is picked so that torque stays roughly level from one position to the next. A position with one winding energized drives that winding at full current. A position with both windings energized drives each at two-thirds. A hold request drops every energized winding to one-third current, which lowers dissipation while the motor stands still.

When a step needs a winding to reverse its polarity, the block switches that winding fully off for a fixed number of clock cycles, so that its current decays fast. The new direction bit is already present during that interval. A strobe that arrives during the interval is queued and taken afterwards. An enable input, when low, switches both bridges off and freezes the position.

Top module: `halfstep_seq`

## Requirements
- R1: The select code uses bit 0 as the low-order select line and bit 1 as the high-order one: 2'b00 is full current, 2'b01 is two-thirds, 2'b10 is one-third and 2'b11 is all drivers off. A winding that is energized alone, outside hold, gets 2'b00. A winding that is not energized gets 2'b11.
- R2: At a position where both windings are energized, and outside hold, both windings get 2'b01. Both windings never show 2'b00 at the same time.
- R3: Positions 0 to 7 carry these winding states (A, B), where + is direction bit 1 and - is direction bit 0: 0:(+,off) 1:(+,+) 2:(off,+) 3:(-,+) 4:(-,off) 5:(-,-) 6:(off,-) 7:(+,-). A step taken with dir_i=1 moves to position+1 and a step taken with dir_i=0 moves to position-1, both modulo 8. The outputs show the new position in the cycle after the clock edge that takes the step.
- R4: When a step energizes a winding with the polarity opposite to its current direction bit, the direction bit takes the new value at that edge, and the winding's code is 2'b11 for exactly DECAY_CYC cycles. A winding that is not energized keeps its last direction bit.
- R5: While hold_i is high, every energized winding gets 2'b10.
- R6: While en_i is low, both codes are 2'b11 and strobes are ignored. Any pending decay and any queued strobe are dropped, and the position and direction bits keep their values.
- R7: A strobe that arrives while a decay interval runs is queued; any number of such strobes count as one step. That step is taken at the first clock edge after the interval has ended. No step is taken while an interval runs.
- R8: After a synchronous reset the block is at position 0, with both direction bits at 1: winding A is at full current and winding B is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step strobe, one step per high cycle when idle |
| dir_i | input | 1 | 1 walks the table forward, 0 walks it backward |
| hold_i | input | 1 | Selects one-third current for energized windings |
| en_i | input | 1 | Low forces both bridges off and freezes the position |
| phase_a_o | output | 1 | Direction bit for the winding A bridge |
| isel_a_o | output | 2 | Current-select code for winding A |
| phase_b_o | output | 1 | Direction bit for the winding B bridge |
| isel_b_o | output | 2 | Current-select code for winding B |

## Verification
The assertions assume that every input changes only between clock edges. They also assume DECAY_CYC is at least one, so that a reversed direction bit always falls inside an off interval. The bench meets both assumptions: it drives inputs only on the falling edge and keeps the default interval of four cycles. Its stimulus includes single strobes, strobes held high for many cycles, strobes spaced closer than the decay interval, reversals of direction, hold, and enable dropping in the middle of an interval. None of these breaks the assumptions, so the assertions apply to every cycle of the run.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    localparam int unsigned POSITIONS = 8;
    localparam int unsigned POS_W     = $clog2(POSITIONS);

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        ISEL_FULL = 2'b00,
        ISEL_HIGH = 2'b01,
        ISEL_LOW  = 2'b10,
        ISEL_OFF  = 2'b11
    } isel_e;

    typedef struct packed {
        logic on;
        logic pol;
    } coil_t;

    typedef struct packed {
        coil_t a;
        coil_t b;
    } pair_t;

    function automatic pair_t pos_to_pair(pos_t p);
        pair_t r;
        r.a.on  = (p != 3'd2) && (p != 3'd6);
        r.a.pol = (p == 3'd7) || (p == 3'd0) || (p == 3'd1);
        r.b.on  = (p != 3'd0) && (p != 3'd4);
        r.b.pol = (p == 3'd1) || (p == 3'd2) || (p == 3'd3);
        return r;
    endfunction

    function automatic isel_e level_for(pair_t s, logic hold);
        if (hold)
            return ISEL_LOW;
        else if (s.a.on && s.b.on)
            return ISEL_HIGH;
        else
            return ISEL_FULL;
    endfunction

endpackage

// File: rtl/hs_pos_ctr.sv
module hs_pos_ctr
    import hs_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  logic dir_i,
    output pos_t pos_o,
    output pos_t pos_nxt_o
);

    pos_t pos_q;

    assign pos_nxt_o = dir_i ? pos_t'(pos_q + 1'b1) : pos_t'(pos_q - 1'b1);
    assign pos_o     = pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (take_i)
            pos_q <= pos_nxt_o;
    end

    // R6 R7
    no_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(pos_q));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (pos_q != $past(pos_q)));

endmodule

// File: rtl/hs_decay_tmr.sv
module hs_decay_tmr #(
    parameter int unsigned DECAY_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic step_i,
    input  logic rev_i,
    input  logic rev_b_i,
    output logic take_o,
    output logic busy_o,
    output logic sel_b_o
);

    localparam int unsigned CNT_W = $clog2(DECAY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             sel_q;

    assign busy_o  = (cnt_q != '0);
    assign take_o  = en_i && !busy_o && (step_i || pend_q);
    assign sel_b_o = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            sel_q  <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (take_o)
                pend_q <= pend_q && step_i;
            else
                pend_q <= pend_q || step_i;
            if (take_o && rev_i) begin
                cnt_q <= CNT_W'(DECAY_CYC);
                sel_q <= rev_b_i;
            end else if (busy_o) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7
    no_take_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !take_o);

    // R7
    strobe_queued_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && busy_o && step_i) |=> pend_q);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DECAY_CYC));

    // R4
    interval_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && busy_o && cnt_q != 1) |=> (busy_o || !en_i));

endmodule

// File: rtl/hs_coil_drv.sv
module hs_coil_drv
    import hs_seq_pkg::*;
#(
    parameter logic PHASE_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       take_i,
    input  coil_t      nxt_i,
    input  coil_t      cur_i,
    input  logic       decay_i,
    input  logic       en_i,
    input  isel_e      level_i,
    output logic       rev_o,
    output logic       phase_o,
    output logic [1:0] isel_o
);

    logic  phase_q;
    isel_e code;

    assign rev_o = take_i && nxt_i.on && (nxt_i.pol != phase_q);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PHASE_RST;
        else if (rev_o)
            phase_q <= nxt_i.pol;
    end

    always_comb begin
        if (!en_i || decay_i || !cur_i.on)
            code = ISEL_OFF;
        else
            code = level_i;
    end

    assign phase_o = phase_q;
    assign isel_o  = code;

    // R4
    flip_while_off_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> (isel_o == ISEL_OFF));

    // R1
    idle_coil_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cur_i.on |-> (isel_o == ISEL_OFF));

endmodule

// File: rtl/halfstep_seq.sv
module halfstep_seq
    import hs_seq_pkg::*;
#(
    parameter int unsigned DECAY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  logic       dir_i,
    input  logic       hold_i,
    input  logic       en_i,
    output logic       phase_a_o,
    output logic [1:0] isel_a_o,
    output logic       phase_b_o,
    output logic [1:0] isel_b_o
);

    localparam int unsigned COILS = 2;

    pos_t  pos, pos_nxt;
    pair_t cur_pair, nxt_pair;
    isel_e level;
    logic  take, busy, sel_b;

    coil_t      cur_c [COILS];
    coil_t      nxt_c [COILS];
    logic       rev_c [COILS];
    logic       ph_c  [COILS];
    logic [1:0] is_c  [COILS];

    hs_pos_ctr u_pos (
        .clk       (clk),
        .rst       (rst),
        .take_i    (take),
        .dir_i     (dir_i),
        .pos_o     (pos),
        .pos_nxt_o (pos_nxt)
    );

    assign cur_pair = pos_to_pair(pos);
    assign nxt_pair = pos_to_pair(pos_nxt);
    assign level    = level_for(cur_pair, hold_i);

    assign cur_c[0] = cur_pair.a;
    assign cur_c[1] = cur_pair.b;
    assign nxt_c[0] = nxt_pair.a;
    assign nxt_c[1] = nxt_pair.b;

    hs_decay_tmr #(.DECAY_CYC(DECAY_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .step_i  (step_i),
        .rev_i   (rev_c[0] || rev_c[1]),
        .rev_b_i (rev_c[1]),
        .take_o  (take),
        .busy_o  (busy),
        .sel_b_o (sel_b)
    );

    for (genvar g = 0; g < COILS; g++) begin : g_coil
        hs_coil_drv #(.PHASE_RST(1'b1)) u_drv (
            .clk     (clk),
            .rst     (rst),
            .take_i  (take),
            .nxt_i   (nxt_c[g]),
            .cur_i   (cur_c[g]),
            .decay_i (busy && (sel_b == 1'(g))),
            .en_i    (en_i),
            .level_i (level),
            .rev_o   (rev_c[g]),
            .phase_o (ph_c[g]),
            .isel_o  (is_c[g])
        );
    end

    assign phase_a_o = ph_c[0];
    assign isel_a_o  = is_c[0];
    assign phase_b_o = ph_c[1];
    assign isel_b_o  = is_c[1];

    // R2
    never_dual_full_chk: assert property (@(posedge clk) disable iff (rst)
        !((isel_a_o == ISEL_FULL) && (isel_b_o == ISEL_FULL)));

    // R6
    disabled_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> ((isel_a_o == ISEL_OFF) && (isel_b_o == ISEL_OFF)));

    // R6
    disabled_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(phase_a_o) && $stable(phase_b_o)));

endmodule

// File: tb/tb_halfstep_seq.sv
module tb_halfstep_seq;

    localparam int DECAY = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_i = 1'b0, dir_i = 1'b1, hold_i = 1'b0, en_i = 1'b1;
    logic       phase_a_o, phase_b_o;
    logic [1:0] isel_a_o, isel_b_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit first  = 1'b1;

    // model state
    int ta [8] = '{1, 1, 0, -1, -1, -1, 0, 1};
    int tb [8] = '{0, 1, 1, 1, 0, -1, -1, -1};
    int m_pos = 0, m_pa = 1, m_pb = 1, m_dc = 0, m_dw = 0, m_pend = 0;
    bit m_stepped = 1'b0;

    always #5 clk = ~clk;

    halfstep_seq #(.DECAY_CYC(DECAY)) dut (
        .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i),
        .hold_i(hold_i), .en_i(en_i),
        .phase_a_o(phase_a_o), .isel_a_o(isel_a_o),
        .phase_b_o(phase_b_o), .isel_b_o(isel_b_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pos = 0; m_pa = 1; m_pb = 1; m_dc = 0; m_dw = 0; m_pend = 0;
            m_stepped = 1'b0;
        end else begin
            bit tk;
            m_stepped = 1'b0;
            tk = en_i && (m_dc == 0) && (step_i || m_pend != 0);
            if (!en_i) begin
                m_dc = 0; m_pend = 0;
            end else if (tk) begin
                m_pend = (m_pend != 0 && step_i) ? 1 : 0;
                m_pos = dir_i ? (m_pos + 1) % 8 : (m_pos + 7) % 8;
                m_stepped = 1'b1;
                if (ta[m_pos] != 0 && ((ta[m_pos] > 0) ? 1 : 0) != m_pa) begin
                    m_pa = (ta[m_pos] > 0) ? 1 : 0; m_dc = DECAY; m_dw = 0;
                end
                if (tb[m_pos] != 0 && ((tb[m_pos] > 0) ? 1 : 0) != m_pb) begin
                    m_pb = (tb[m_pos] > 0) ? 1 : 0; m_dc = DECAY; m_dw = 1;
                end
            end else begin
                if (m_dc > 0) m_dc--;
                if (step_i) m_pend = 1;
            end
        end
    end

    function automatic int exp_code(int v, int coil);
        if (!en_i) return 3;
        if (m_dc > 0 && m_dw == coil) return 3;
        if (v == 0) return 3;
        if (hold_i) return 2;
        if (ta[m_pos] != 0 && tb[m_pos] != 0) return 1;
        return 0;
    endfunction

    task automatic compare();
        string tag;
        int ea, eb;
        ea = exp_code(ta[m_pos], 0);
        eb = exp_code(tb[m_pos], 1);
        if (first)               tag = "R8";
        else if (!en_i)          tag = "R6";
        else if (m_dc > 0)       tag = "R4";
        else if (m_pend != 0)    tag = "R7";
        else if (m_stepped)      tag = "R3";
        else if (hold_i)         tag = "R5";
        else if (ta[m_pos] != 0 && tb[m_pos] != 0) tag = "R2";
        else                     tag = "R1";
        first = 1'b0;
        checks++;
        if (phase_a_o !== m_pa[0] || phase_b_o !== m_pb[0] ||
            isel_a_o !== ea[1:0] || isel_b_o !== eb[1:0]) begin
            fails++;
            $display("FAIL %s pos=%0d actual pa=%b ia=%b pb=%b ib=%b expected pa=%0d ia=%0d pb=%0d ib=%0d",
                     tag, m_pos, phase_a_o, isel_a_o, phase_b_o, isel_b_o,
                     m_pa, ea, m_pb, eb);
        end
    endtask

    task automatic cyc(input logic s, input logic d, input logic h, input logic e);
        @(negedge clk);
        if (!rst) compare();
        step_i = s; dir_i = d; hold_i = h; en_i = e;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual cycles=%0d expected under 100000", cycles);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state, idle cycles
        repeat (3) cyc(0, 1, 0, 1);
        // R3 R1 R2 R4 forward single steps with wide gaps, wraps past 7
        for (int i = 0; i < 10; i++) begin
            cyc(1, 1, 0, 1);
            repeat (8) cyc(0, 1, 0, 1);
        end
        // R7 strobe held high for many cycles
        repeat (25) cyc(1, 1, 0, 1);
        repeat (8) cyc(0, 1, 0, 1);
        // R3 R7 reverse steps closer than the decay interval
        for (int i = 0; i < 12; i++) begin
            cyc(1, 0, 0, 1);
            repeat (2) cyc(0, 0, 0, 1);
        end
        repeat (10) cyc(0, 0, 0, 1);
        // R5 hold with steps
        for (int i = 0; i < 6; i++) begin
            cyc(1, 1, 1, 1);
            repeat (6) cyc(0, 1, 1, 1);
        end
        // R6 disable during an interval, with strobes ignored
        cyc(1, 1, 0, 1);
        cyc(1, 1, 0, 1);
        repeat (6) cyc(1, 1, 0, 0);
        repeat (4) cyc(0, 1, 0, 0);
        repeat (6) cyc(0, 1, 0, 1);
        // mixed directions at full rate
        for (int i = 0; i < 40; i++) cyc(1, (i % 7) < 4, (i % 11) == 3, (i % 13) != 5);
        repeat (10) cyc(0, 1, 0, 1);
        finish_run();
    end

endmodule